// File: doc/BRIEF.md
# Timer Interrupt Request and Acceptance Controller

This block serves a single timer interrupt source inside a small 4-bit processor core. It samples the timer pulse on the system clock and latches a request flag when the pulse falls. Software can also set or cancel this flag through a write port. The request flag is combined with a global enable and a per-source permission flag. The global enable is raised by an enable-interrupts strobe and dropped by a disable-interrupts strobe. The core signals each instruction boundary, and acceptance happens only there, so an instruction is never cut in half.

When a request is accepted, the block tells the core to load the fixed entry address 0x003. In the same cycle it pushes a context record onto a small internal return stack. The record holds the core's return address, its bank register and its index-enable flag. A return-from-interrupt strobe pops the newest record and hands all three values back to the core. Acceptance also drops the global enable, so interrupts do not nest unless software enables them again.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: The request flag becomes 1 at the clock edge where the pulse input is sampled low and the previous sample was high. A rising pulse never sets it. After reset the previous sample counts as low.
- R2: `irq_take_o` is 1 only when all of these hold in the cycle: `instr_bnd_i` is 1, the global enable is 1, the permission flag is 1, the request flag is 1, and `reti_i` is 0.
- R3: In an accepting cycle, `pc_load_o` is 1, `pc_next_o` equals 0x003, and `ctx_load_o` is 0.
- R4: The clock edge that ends an accepting cycle clears both the request flag and the global enable.
- R5: A request latched while blocked stays pending. It is taken at the first instruction boundary after the missing enable (global enable or permission) has been set.
- R6: Writing 1 to the request flag raises a request. Writing 0 cancels it. A falling pulse edge in the same cycle as a write of 0 leaves the flag at 1.
- R7: Each acceptance pushes one stack record. The record holds `cur_pc_i`, `cur_bank_i` and `cur_ixe_i` as sampled in the accepting cycle.
- R8: A `reti_i` cycle with a non-empty stack drives `pc_load_o`=1 and `ctx_load_o`=1. It also drives `pc_next_o`, `ctx_bank_o` and `ctx_ixe_o` from the newest record, and removes that record. A `reti_i` cycle with an empty stack drives neither load.
- R9: Records pop in reverse order of acceptance (last in, first out).
- R10: An acceptance with the stack already holding STK_DEPTH records sets `stk_ovf_o`, which stays 1 until reset. The new record replaces the oldest one, so after STK_DEPTH pops the stack reads as empty.
- R11: Reset clears the request flag, the permission flag, the global enable and the overflow flag. `ei_i` sets the global enable and `di_i` clears it. When both strobes arrive in the same cycle, `di_i` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_pulse_i | input | 1 | Timer interrupt pulse; its falling edge requests |
| instr_bnd_i | input | 1 | Instruction boundary strobe from the core |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| cur_pc_i | input | PC_W | Return address to save on acceptance |
| cur_bank_i | input | BANK_W | Current bank register value |
| cur_ixe_i | input | 1 | Current index-enable flag |
| req_wr_en_i | input | 1 | Software write strobe for the request flag |
| req_wr_val_i | input | 1 | Value written to the request flag |
| perm_wr_en_i | input | 1 | Software write strobe for the permission flag |
| perm_wr_val_i | input | 1 | Value written to the permission flag |
| req_flag_o | output | 1 | Request flag |
| perm_flag_o | output | 1 | Permission flag |
| gie_o | output | 1 | Global interrupt enable |
| irq_take_o | output | 1 | Acceptance in this cycle |
| pc_load_o | output | 1 | Core must load `pc_next_o` |
| pc_next_o | output | PC_W | Entry address or restored return address |
| ctx_load_o | output | 1 | Core must restore bank and index-enable |
| ctx_bank_o | output | BANK_W | Restored bank register value |
| ctx_ixe_o | output | 1 | Restored index-enable flag |
| stk_ovf_o | output | 1 | Sticky return stack overflow |

## Verification
The hardest state to reach from the ports is a full stack that receives one more push and then unwinds. Each nested acceptance needs a fresh enable strobe, a new request and a boundary strobe, in that order, and the block itself drops the global enable after every acceptance. The stimulus repeats that three-step pattern STK_DEPTH+1 times with a distinct address and bank per level. It then issues returns and expects the newest records in reverse order. The oldest record must be missing, and a final return must produce no load.

// File: rtl/tmr_irq_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and the program-counter source encoding for the
// timer interrupt controller. Assumes a core with a 12-bit program counter.
package tmr_irq_pkg;

    parameter int unsigned DEF_PC_W      = 12;
    parameter int unsigned DEF_BANK_W    = 4;
    parameter int unsigned DEF_STK_DEPTH = 4;
    parameter int unsigned DEF_VEC_ADDR  = 32'h003;

    // Which value the core must load into its program counter this cycle.
    typedef enum logic [1:0] {
        PCSRC_NONE = 2'd0,
        PCSRC_VEC  = 2'd1,
        PCSRC_RET  = 2'd2
    } pc_src_e;

endpackage

// File: rtl/tmr_irq_edge.sv
`timescale 1ns/1ps
// Module: tmr_irq_edge
// Samples the timer pulse on clk and holds the request flag.
// The flag is set by a falling edge or by a software write of 1.
// It is cleared by acceptance or by a software write of 0, and a hardware
// edge takes priority over both clears.
// Assumes the pulse is synchronous to clk, or has been synchronized upstream.
module tmr_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    input  logic wr_en_i,
    input  logic wr_val_i,
    input  logic clr_i,
    output logic fall_o,
    output logic req_o
);

    logic pulse_q;
    logic req_q;

    // Hold the previous pulse sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= pulse_i;
    end

    assign fall_o = pulse_q & ~pulse_i;

    // Request flag: a set (edge or write of 1) beats a clear (accept or write of 0).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (fall_o || (wr_en_i && wr_val_i)) begin
            req_q <= 1'b1;
        end else if (clr_i || wr_en_i) begin
            req_q <= 1'b0;
        end
    end

    assign req_o = req_q;

    AST_FALL_SETS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> req_q); // R1
    AST_WR0_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_val_i && !fall_o) |=> !req_q); // R6

endmodule

// File: rtl/tmr_irq_gate.sv
`timescale 1ns/1ps
// Module: tmr_irq_gate
// Holds the global enable and the per-source permission flag, and decides
// acceptance at instruction boundaries.
// Acceptance drops the global enable. A return strobe in the same cycle
// blocks acceptance, so push and pop never collide.
module tmr_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ei_i,
    input  logic di_i,
    input  logic perm_wr_en_i,
    input  logic perm_wr_val_i,
    input  logic bnd_i,
    input  logic req_i,
    input  logic reti_i,
    output logic gie_o,
    output logic perm_o,
    output logic take_o
);

    logic gie_q;
    logic perm_q;

    // Acceptance condition, evaluated only on a boundary.
    always_comb begin
        take_o = bnd_i & gie_q & perm_q & req_i & ~reti_i;
    end

    // Global enable: accept and DI clear it, EI sets it, DI beats EI.
    always_ff @(posedge clk) begin
        if (!rst_n)           gie_q <= 1'b0;
        else if (take_o)      gie_q <= 1'b0;
        else if (di_i)        gie_q <= 1'b0;
        else if (ei_i)        gie_q <= 1'b1;
    end

    // Permission flag, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)            perm_q <= 1'b0;
        else if (perm_wr_en_i) perm_q <= perm_wr_val_i;
    end

    assign gie_o  = gie_q;
    assign perm_o = perm_q;

    AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !gie_q); // R4
    AST_DI_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        di_i |=> !gie_q); // R11

endmodule

// File: rtl/tmr_irq_stack.sv
`timescale 1ns/1ps
// Module: tmr_irq_stack
// A circular return stack of DEPTH records, each ENT_W bits wide.
// Pushing onto a full stack overwrites the oldest record and sets a sticky
// overflow flag. Popping an empty stack does nothing.
// Assumes push and pop never arrive in the same cycle.
module tmr_irq_stack #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned ENT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [ENT_W-1:0] push_dat_i,
    input  logic             pop_i,
    output logic             pop_vld_o,
    output logic [ENT_W-1:0] pop_dat_o,
    output logic             ovf_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [ENT_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_idx_q;
    logic [PTR_W-1:0] rd_idx;
    logic [PTR_W-1:0] wr_idx_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    // Neighbouring slot indices with wrap-around.
    always_comb begin
        rd_idx     = (wr_idx_q == '0) ? LAST_IDX : wr_idx_q - 1'b1;
        wr_idx_nxt = (wr_idx_q == LAST_IDX) ? '0 : wr_idx_q + 1'b1;
    end

    assign pop_vld_o = pop_i && (cnt_q != '0);
    assign pop_dat_o = mem_q[rd_idx];
    assign ovf_o     = ovf_q;

    // Record storage: each slot loads when it is the write target of a push.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem_q[g] <= '0;
                else if (push_i && (wr_idx_q == PTR_W'(g)))
                    mem_q[g] <= push_dat_i;
            end
        end
    endgenerate

    // Pointer, occupancy and overflow bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx_q <= '0;
            cnt_q    <= '0;
            ovf_q    <= 1'b0;
        end else if (push_i) begin
            wr_idx_q <= wr_idx_nxt;
            if (cnt_q == FULL_CNT) ovf_q <= 1'b1;
            else                   cnt_q <= cnt_q + 1'b1;
        end else if (pop_vld_o) begin
            wr_idx_q <= rd_idx;
            cnt_q    <= cnt_q - 1'b1;
        end
    end

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && cnt_q != FULL_CNT) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R7
    AST_FULL_PUSH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && cnt_q == FULL_CNT) |=> (ovf_q && cnt_q == FULL_CNT)); // R10
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q); // R10

endmodule

// File: rtl/tmr_irq_ctrl.sv
`timescale 1ns/1ps
// Module: tmr_irq_ctrl (top)
// Timer interrupt request, acceptance and context save/restore for one source.
// Joins the edge detector, the enable gate and the return stack, and selects
// the program counter value handed to the core.
// Assumes the core obeys pc_load_o/ctx_load_o in the cycle they are high,
// and that cur_pc_i already holds the address to resume at.
module tmr_irq_ctrl
    import tmr_irq_pkg::*;
#(
    parameter int unsigned PC_W      = DEF_PC_W,
    parameter int unsigned BANK_W    = DEF_BANK_W,
    parameter int unsigned STK_DEPTH = DEF_STK_DEPTH,
    parameter int unsigned VEC_ADDR  = DEF_VEC_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_pulse_i,
    input  logic              instr_bnd_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              reti_i,
    input  logic [PC_W-1:0]   cur_pc_i,
    input  logic [BANK_W-1:0] cur_bank_i,
    input  logic              cur_ixe_i,
    input  logic              req_wr_en_i,
    input  logic              req_wr_val_i,
    input  logic              perm_wr_en_i,
    input  logic              perm_wr_val_i,
    output logic              req_flag_o,
    output logic              perm_flag_o,
    output logic              gie_o,
    output logic              irq_take_o,
    output logic              pc_load_o,
    output logic [PC_W-1:0]   pc_next_o,
    output logic              ctx_load_o,
    output logic [BANK_W-1:0] ctx_bank_o,
    output logic              ctx_ixe_o,
    output logic              stk_ovf_o
);

    localparam int unsigned ENT_W = PC_W + BANK_W + 1;
    localparam logic [PC_W-1:0] VEC = PC_W'(VEC_ADDR);

    logic             take;
    logic             req;
    logic             fall;
    logic             pop_vld;
    logic [ENT_W-1:0] push_dat;
    logic [ENT_W-1:0] pop_dat;
    pc_src_e          pc_src;

    tmr_irq_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_i  (tmr_pulse_i),
        .wr_en_i  (req_wr_en_i),
        .wr_val_i (req_wr_val_i),
        .clr_i    (take),
        .fall_o   (fall),
        .req_o    (req)
    );

    tmr_irq_gate u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .ei_i          (ei_i),
        .di_i          (di_i),
        .perm_wr_en_i  (perm_wr_en_i),
        .perm_wr_val_i (perm_wr_val_i),
        .bnd_i         (instr_bnd_i),
        .req_i         (req),
        .reti_i        (reti_i),
        .gie_o         (gie_o),
        .perm_o        (perm_flag_o),
        .take_o        (take)
    );

    // Pack the context record: return address, bank, index-enable.
    assign push_dat = {cur_pc_i, cur_bank_i, cur_ixe_i};

    tmr_irq_stack #(
        .DEPTH (STK_DEPTH),
        .ENT_W (ENT_W)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (take),
        .push_dat_i (push_dat),
        .pop_i      (reti_i),
        .pop_vld_o  (pop_vld),
        .pop_dat_o  (pop_dat),
        .ovf_o      (stk_ovf_o)
    );

    // Choose the program counter source for this cycle.
    always_comb begin
        if (take)         pc_src = PCSRC_VEC;
        else if (pop_vld) pc_src = PCSRC_RET;
        else              pc_src = PCSRC_NONE;
    end

    // Drive the core-facing load controls and values.
    always_comb begin
        pc_load_o  = (pc_src != PCSRC_NONE);
        ctx_load_o = (pc_src == PCSRC_RET);
        pc_next_o  = (pc_src == PCSRC_VEC) ? VEC : pop_dat[ENT_W-1 -: PC_W];
        ctx_bank_o = pop_dat[BANK_W:1];
        ctx_ixe_o  = pop_dat[0];
    end

    assign req_flag_o = req;
    assign irq_take_o = take;

    AST_ONE_LOAD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_take_o && ctx_load_o)); // R2
    AST_TAKE_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take_o && !fall && !(req_wr_en_i && req_wr_val_i)) |=> !req_flag_o); // R4

endmodule

// File: tb/tmr_irq_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench for tmr_irq_ctrl. Directed tasks drive the stimulus and
// queue the expected program-counter loads. A negedge monitor pops and
// compares each load when the design produces it.
module tmr_irq_ctrl_bench;

    localparam int PC_W   = 12;
    localparam int BANK_W = 4;
    localparam int DEPTH  = 4;

    typedef struct {
        logic [PC_W-1:0]   pc;
        logic              ctx;
        logic [BANK_W-1:0] bank;
        logic              ixe;
        string             tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tmr_pulse = 1'b0, bnd = 1'b0, ei = 1'b0, di = 1'b0, reti = 1'b0;
    logic [PC_W-1:0]   cur_pc = '0;
    logic [BANK_W-1:0] cur_bank = '0;
    logic cur_ixe = 1'b0;
    logic req_wr_en = 1'b0, req_wr_val = 1'b0, perm_wr_en = 1'b0, perm_wr_val = 1'b0;
    logic req_flag, perm_flag, gie, take, pc_load, ctx_load, ctx_ixe, stk_ovf;
    logic [PC_W-1:0]   pc_next;
    logic [BANK_W-1:0] ctx_bank;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    tmr_irq_ctrl u_tmr_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .tmr_pulse_i(tmr_pulse), .instr_bnd_i(bnd),
        .ei_i(ei), .di_i(di), .reti_i(reti), .cur_pc_i(cur_pc),
        .cur_bank_i(cur_bank), .cur_ixe_i(cur_ixe),
        .req_wr_en_i(req_wr_en), .req_wr_val_i(req_wr_val),
        .perm_wr_en_i(perm_wr_en), .perm_wr_val_i(perm_wr_val),
        .req_flag_o(req_flag), .perm_flag_o(perm_flag), .gie_o(gie),
        .irq_take_o(take), .pc_load_o(pc_load), .pc_next_o(pc_next),
        .ctx_load_o(ctx_load), .ctx_bank_o(ctx_bank), .ctx_ixe_o(ctx_ixe),
        .stk_ovf_o(stk_ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Advance one cycle; one-cycle strobes drop after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
        bnd = 1'b0; ei = 1'b0; di = 1'b0; reti = 1'b0;
        req_wr_en = 1'b0; perm_wr_en = 1'b0;
    endtask

    task automatic expect_load(input logic [PC_W-1:0] pc, input logic ctx,
                               input logic [BANK_W-1:0] bank, input logic ixe,
                               input string tag);
        exp_t e;
        e.pc = pc; e.ctx = ctx; e.bank = bank; e.ixe = ixe; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare every load against the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && pc_load) begin
            if (exp_q.size() == 0) begin
                chk("R3 R8 unexpected load pc", {20'h0, pc_next}, 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " pc"}, {20'h0, pc_next}, {20'h0, e.pc});
                chk({e.tag, " ctx_load"}, {31'h0, ctx_load}, {31'h0, e.ctx});
                if (e.ctx) begin
                    chk({e.tag, " bank"}, {28'h0, ctx_bank}, {28'h0, e.bank});
                    chk({e.tag, " ixe"}, {31'h0, ctx_ixe}, {31'h0, e.ixe});
                end
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk("R11 reset req", {31'h0, req_flag}, 0);
        chk("R11 reset perm", {31'h0, perm_flag}, 0);
        chk("R11 reset gie", {31'h0, gie}, 0);
        chk("R11 reset ovf", {31'h0, stk_ovf}, 0);
        chk("R11 reset pc_load", {31'h0, pc_load}, 0);

        // R1: rising edge must not set, falling edge must set
        tmr_pulse = 1'b1; tick(); tick();
        chk("R1 rise no set", {31'h0, req_flag}, 0);
        tmr_pulse = 1'b0; tick();
        chk("R1 fall sets", {31'h0, req_flag}, 1);

        // R2/R5: pending while blocked
        bnd = 1'b1; #1;
        chk("R2 no take without gie", {31'h0, take}, 0);
        tick();
        chk("R5 request pending", {31'h0, req_flag}, 1);
        ei = 1'b1; tick();
        chk("R11 ei sets gie", {31'h0, gie}, 1);
        bnd = 1'b1; #1;
        chk("R2 no take without perm", {31'h0, take}, 0);
        tick();
        perm_wr_en = 1'b1; perm_wr_val = 1'b1; tick();
        chk("R5 perm written", {31'h0, perm_flag}, 1);
        #1 chk("R2 no take off boundary", {31'h0, take}, 0);
        cur_pc = 12'h123; cur_bank = 4'h5; cur_ixe = 1'b1; bnd = 1'b1;
        expect_load(12'h003, 1'b0, 4'h0, 1'b0, "R3");
        #1 chk("R5 take after perm set", {31'h0, take}, 1);
        tick();
        chk("R4 req cleared", {31'h0, req_flag}, 0);
        chk("R4 gie cleared", {31'h0, gie}, 0);

        // R7/R8: return restores record; empty return does nothing
        expect_load(12'h123, 1'b1, 4'h5, 1'b1, "R7 R8");
        reti = 1'b1; tick();
        reti = 1'b1; #1;
        chk("R8 empty reti no load", {31'h0, pc_load}, 0);
        tick();

        // R6: software writes and edge priority
        req_wr_en = 1'b1; req_wr_val = 1'b1; tick();
        chk("R6 write 1 sets", {31'h0, req_flag}, 1);
        req_wr_en = 1'b1; req_wr_val = 1'b0; tick();
        chk("R6 write 0 cancels", {31'h0, req_flag}, 0);
        tmr_pulse = 1'b1; tick();
        tmr_pulse = 1'b0; req_wr_en = 1'b1; req_wr_val = 1'b0; tick();
        chk("R6 edge beats write 0", {31'h0, req_flag}, 1);
        req_wr_en = 1'b1; req_wr_val = 1'b0; tick();

        // R11: enable strobes and priority
        ei = 1'b1; di = 1'b1; tick();
        chk("R11 di beats ei", {31'h0, gie}, 0);
        ei = 1'b1; tick();
        di = 1'b1; tick();
        chk("R11 di clears", {31'h0, gie}, 0);

        // R2: reti in the boundary cycle blocks acceptance
        ei = 1'b1; tick();
        req_wr_en = 1'b1; req_wr_val = 1'b1; tick();
        bnd = 1'b1; reti = 1'b1; #1;
        chk("R2 reti blocks take", {31'h0, take}, 0);
        tick();
        req_wr_en = 1'b1; req_wr_val = 1'b0; di = 1'b1; tick();

        // R9/R10: nest DEPTH+1 levels; each needs EI, request, boundary
        for (int k = 0; k <= DEPTH; k++) begin
            if (k == DEPTH) chk("R10 no ovf at full", {31'h0, stk_ovf}, 0);
            ei = 1'b1; tick();
            req_wr_en = 1'b1; req_wr_val = 1'b1; tick();
            cur_pc = 12'h200 + 12'(k); cur_bank = 4'(k); cur_ixe = k[0];
            bnd = 1'b1;
            expect_load(12'h003, 1'b0, 4'h0, 1'b0, "R9 vector");
            tick();
        end
        chk("R10 ovf set", {31'h0, stk_ovf}, 1);
        for (int k = DEPTH; k >= 1; k--) begin
            expect_load(12'h200 + 12'(k), 1'b1, 4'(k), k[0], "R9 R10 pop order");
            reti = 1'b1; tick();
        end
        reti = 1'b1; #1;
        chk("R10 oldest overwritten", {31'h0, pc_load}, 0);
        tick();
        chk("R10 ovf sticky", {31'h0, stk_ovf}, 1);
        tick(); tick();
        chk("R3 R8 all loads seen", exp_q.size(), 0);
        finish_run();
    end

endmodule